// File: doc/BRIEF.md
# MDIO Management Master with Host Command Registers

This block lets a host read and write registers in external Ethernet PHYs over the two-wire management bus. The host sees three 16-bit registers. Writing the command register with one operation bit set and a packed PHY/register address launches a Clause 22 frame. For a write, the data is staged beforehand in a separate write-data register. The result of a read appears in a read-data register.

Progress is polled through the command register. The operation bit stays set for the whole frame and clears by itself when the frame ends. The management clock is divided down from the system clock. The data line leaves the block as an output value plus an output enable, which the pad turns into a tristate pin.

Top module: `mdio_mgmt_frontend`

## Requirements
- R1: After reset the command, write-data and read-data registers all read 0x0000.
- R2: Command word layout: bit 14 requests a write, bit 13 requests a read, bits 12:8 hold the PHY address and bits 4:0 the register number. A command written while idle starts a frame only if exactly one of bits 14 and 13 is set. A command with both bits set, or with neither, is ignored and leaves the command readback unchanged.
- R3: The command register reads back {0, write-busy, read-busy, PHY[4:0], 000, REG[4:0]} for the last accepted command. The operation bit reads 1 from the clock edge that accepts the command until the frame ends, and 0 after that.
- R4: A command written while a frame is running has no effect on the frame or on the command readback.
- R5: MDC is low while idle. During a frame it toggles every HALF_DIV system clocks, with the first rising edge HALF_DIV clocks after the accepting edge. A frame holds exactly 64 MDC periods.
- R6: Frame bit order, each field MSB first: 32 ones, start 01, opcode 01 (write) or 10 (read), PHY address, register number, turnaround 10 (write only), then 16 data bits.
- R7: The master changes MDIO only on a falling edge of MDC, or at the edge that accepts the command.
- R8: In a read frame the output enable drops at the start of the turnaround (frame bit 46) and stays low to the end of the frame. Bits 48..63 are sampled on MDC rising edges, MSB first. The 16-bit result is loaded into the read-data register at the edge where the frame ends, and that register changes at no other time.
- R9: A write frame carries the write-data value held at the accepting edge. Later writes to write-data do not change the frame in progress.
- R10: Host addresses: 0 is the command register, 1 is write-data (readable), 2 is read-data (host writes have no effect), and 3 reads 0x0000.
- R11: While no frame is running the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Host write strobe for one cycle |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data for reg_addr, combinational |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_out | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |
| mdio_in | input | 1 | MDIO line value from the pad |

## Verification
On every cycle the assertions check several properties. MDC and the output enable stay quiet while idle. MDIO moves only on falling MDC edges. An accepted command stays frozen for the whole frame. The read-data register changes only at the end of a frame, and the output enable is released only on a falling edge.

Other properties need the bench's scenarios and its cycle-by-cycle reference: the exact content of each frame bit and the timing of the MDC edges. The same holds for the rejection of malformed commands, commands issued while busy, and late write-data updates. Finally, the scenarios show that the PHY's data bits end up in the read-data register in the right order.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int CMD_WR_BIT = 14;
  localparam int CMD_RD_BIT = 13;
  localparam int PHY_LSB    = 8;

  typedef enum logic [1:0] {
    HR_CMD   = 2'd0,
    HR_WDATA = 2'd1,
    HR_RDATA = 2'd2,
    HR_NONE  = 2'd3
  } host_reg_e;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
  } mdio_cmd_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap      = (cnt_q == CW'(HALF_DIV - 1));
  assign rise_tick = run & wrap & ~mdc_q;
  assign fall_tick = run & wrap &  mdc_q;
  assign mdc       = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         cmd_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_in,
  output logic              busy,
  output logic              done,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_result
);
  localparam int CNT_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh_q, sh_d, launch_frame;
  logic [CNT_W-1:0]      idx_q, idx_d;
  logic                  busy_q, busy_d;
  logic                  rd_q, rd_d;
  logic [DATA_W-1:0]     cap_q, cap_d;
  logic                  last_bit;

  assign last_bit = (idx_q == CNT_W'(FRAME_BITS - 1));

  // Frame image, shifted out MSB first
  always_comb begin
    launch_frame = {{PRE_BITS{1'b1}}, 2'b01,
                    (cmd_in.rd ? 2'b10 : 2'b01),
                    cmd_in.phy, cmd_in.regad,
                    (cmd_in.rd ? 2'b11 : 2'b10),
                    (cmd_in.rd ? {DATA_W{1'b1}} : wdata_in)};
  end

  always_comb begin
    sh_d   = sh_q;
    idx_d  = idx_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    cap_d  = cap_q;
    if (start && !busy_q) begin
      sh_d   = launch_frame;
      idx_d  = '0;
      busy_d = 1'b1;
      rd_d   = cmd_in.rd;
    end else if (busy_q) begin
      if (rise_tick && rd_q && (idx_q >= CNT_W'(DATA_POS)))
        cap_d = {cap_q[DATA_W-2:0], mdio_in};
      if (fall_tick) begin
        if (last_bit) begin
          busy_d = 1'b0;
        end else begin
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
          idx_d = idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      cap_q  <= '0;
    end else begin
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
      cap_q  <= cap_d;
    end
  end

  assign busy      = busy_q;
  assign done      = busy_q & fall_tick & last_bit;
  assign mdio_out  = sh_q[FRAME_BITS-1];
  assign mdio_oe   = busy_q & (~rd_q | (idx_q < CNT_W'(TA_POS)));
  assign rd_result = cap_q;
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_result,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              start,
  output mdio_cmd_t         cmd_new,
  output mdio_cmd_t         cmd_acc,
  output logic [DATA_W-1:0] wdata_val,
  output logic [DATA_W-1:0] rdata_val
);
  host_reg_e         sel;
  mdio_cmd_t         cmd_q, cmd_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              op_wr, op_rd;

  assign sel   = host_reg_e'(reg_addr);
  assign op_wr = reg_wdata[CMD_WR_BIT];
  assign op_rd = reg_wdata[CMD_RD_BIT];
  assign cmd_new.rd    = op_rd;
  assign cmd_new.phy   = reg_wdata[PHY_LSB +: ADDR_W];
  assign cmd_new.regad = reg_wdata[ADDR_W-1:0];
  assign start = reg_wr & (sel == HR_CMD) & ~busy & (op_wr ^ op_rd);

  always_comb begin
    cmd_d   = cmd_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    if (start) cmd_d = cmd_new;
    if (reg_wr && (sel == HR_WDATA)) wdata_d = reg_wdata;
    if (done && cmd_q.rd) rdata_d = rd_result;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      cmd_q   <= cmd_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

  always_comb begin
    case (sel)
      HR_CMD:   reg_rdata = {1'b0, busy & ~cmd_q.rd, busy & cmd_q.rd,
                             cmd_q.phy, 3'b000, cmd_q.regad};
      HR_WDATA: reg_rdata = wdata_q;
      HR_RDATA: reg_rdata = rdata_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign cmd_acc   = cmd_q;
  assign wdata_val = wdata_q;
  assign rdata_val = rdata_q;
endmodule

// File: rtl/mdio_mgmt_frontend.sv
module mdio_mgmt_frontend
  import mdio_mgmt_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              start, seq_busy, seq_done, rise_tick, fall_tick;
  mdio_cmd_t         cmd_new, acc_cmd;
  logic [DATA_W-1:0] wdata_val, rdata_val, rd_result;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  mdio_host_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(seq_busy), .done(seq_done),
    .rd_result(rd_result), .reg_rdata(reg_rdata), .start(start),
    .cmd_new(cmd_new), .cmd_acc(acc_cmd), .wdata_val(wdata_val),
    .rdata_val(rdata_val)
  );

  mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .run(seq_busy), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .cmd_in(cmd_new),
    .wdata_in(wdata_val), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdio_in(mdio_in), .busy(seq_busy), .done(seq_done),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .rd_result(rd_result)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker
  import mdio_mgmt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mdc,
  input logic              mdio_out,
  input logic              mdio_oe,
  input mdio_cmd_t         acc_cmd,
  input logic [DATA_W-1:0] rdata
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc)); // R11

  AST_MDC_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy); // R5

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_out)); // R7

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(acc_cmd)); // R4

  AST_RDATA_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> $past(done)); // R8

  AST_OE_DROP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mdio_oe) && busy) |-> $fell(mdc)); // R8
endmodule

bind mdio_mgmt_frontend mdio_mgmt_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .busy(seq_busy), .done(seq_done),
  .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
  .acc_cmd(acc_cmd), .rdata(rdata_val)
);

// File: tb/sim_mdio_mgmt_frontend.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_frontend;
  localparam int HD = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe, mdio_in;

  int checks = 0;
  int errors = 0;
  int prints = 0;
  int rises  = 0;
  logic prev_mdc = 1'b0;

  // behavioural reference state
  bit          m_busy, m_rd;
  int          t;
  logic [63:0] m_frame;
  logic [15:0] m_wdata, m_rdata, m_rval;
  logic [4:0]  m_phy, m_reg;
  int          k, bitn;
  logic        e_mdc, e_oe, e_out;

  always #2.5 clk = ~clk;

  mdio_mgmt_frontend #(.HALF_DIV(HD)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_rd = 0; t = 0; m_frame = '0;
      m_wdata = '0; m_rdata = '0; m_phy = '0; m_reg = '0;
    end else begin
      if (m_busy) begin
        t = t + 1;
        if (t == 128 * HD) begin
          m_busy = 0;
          if (m_rd) m_rdata = m_rval;
        end
      end else if (reg_wr && reg_addr == 2'd0 && (reg_wdata[14] != reg_wdata[13])) begin
        m_busy  = 1;
        t       = 0;
        m_rd    = reg_wdata[13];
        m_phy   = reg_wdata[12:8];
        m_reg   = reg_wdata[4:0];
        m_frame = {32'hFFFF_FFFF, 2'b01, (m_rd ? 2'b10 : 2'b01), m_phy, m_reg, 2'b10, m_wdata};
      end
      if (reg_wr && reg_addr == 2'd1) m_wdata = reg_wdata;
    end
  end

  // per-cycle comparison and PHY model (R5, R6, R7, R8, R11)
  always @(negedge clk) begin
    if (rst_n) begin
      k     = t / HD;
      bitn  = k / 2;
      e_mdc = m_busy ? k[0] : 1'b0;
      e_oe  = m_busy && (!m_rd || bitn < 46);
      e_out = m_frame[63 - (m_busy ? bitn : 0)];
      checks++;
      if (mdc !== e_mdc || mdio_oe !== e_oe || (e_oe && mdio_out !== e_out)) begin
        errors++;
        if (prints < 12) begin
          prints++;
          $display("FAIL R5/R6/R7/R11 t=%0d: mdc=%b oe=%b out=%b expected mdc=%b oe=%b out=%b",
                   t, mdc, mdio_oe, mdio_out, e_mdc, e_oe, e_out);
        end
      end
      if (mdc && !prev_mdc) rises++;
      prev_mdc = mdc;
      if (m_busy && m_rd && bitn >= 48) mdio_in = m_rval[63 - bitn];
      else if (m_busy && m_rd && bitn == 47) mdio_in = 1'b0;
      else mdio_in = 1'b1;
    end
  end

  task automatic host_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %0d: got %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    mdio_in = 1'b1; m_rval = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd_chk(2'd0, 16'h0000, "R1 cmd");
    rd_chk(2'd1, 16'h0000, "R1 wdata");
    rd_chk(2'd2, 16'h0000, "R1 rdata");

    host_write(2'd1, 16'hA5C3);
    rd_chk(2'd1, 16'hA5C3, "R10 wdata readback");
    rises = 0;
    host_write(2'd0, 16'h4511);
    rd_chk(2'd0, 16'h4511, "R3 write busy");
    repeat (40) @(negedge clk);
    host_write(2'd1, 16'h0000);       // R9: late write-data update
    host_write(2'd0, 16'h2305);       // R4: command while busy
    rd_chk(2'd0, 16'h4511, "R4 busy cmd ignored");
    wait_idle();
    rd_chk(2'd0, 16'h0511, "R3 write bit cleared");
    checks++;
    if (rises != 64) begin
      errors++;
      $display("FAIL R5 mdc rises per frame: got %0d expected 64", rises);
    end

    m_rval = 16'hBEEF;
    host_write(2'd0, 16'h3F1F);
    rd_chk(2'd0, 16'h3F1F, "R3 read busy");
    wait_idle();
    rd_chk(2'd2, 16'hBEEF, "R8 read result");
    rd_chk(2'd0, 16'h1F1F, "R3 read bit cleared");

    host_write(2'd0, 16'h6102);
    rd_chk(2'd0, 16'h1F1F, "R2 both op bits");
    repeat (6) @(negedge clk);
    host_write(2'd0, 16'h0102);
    rd_chk(2'd0, 16'h1F1F, "R2 no op bit");

    host_write(2'd2, 16'h1234);
    rd_chk(2'd2, 16'hBEEF, "R10 rdata write ignored");
    rd_chk(2'd3, 16'h0000, "R10 unused address");

    m_rval = 16'h0001;
    host_write(2'd0, 16'h2000);
    wait_idle();
    rd_chk(2'd2, 16'h0001, "R8 boundary result");

    host_write(2'd1, 16'hFFFF);
    host_write(2'd0, 16'h5F00);
    wait_idle();
    rd_chk(2'd0, 16'h1F00, "R6 write frame end");
    rd_chk(2'd2, 16'h0001, "R8 rdata kept after write");

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule